// File: doc/BRIEF.md
# Conversion Start and Settling Sequencer

This block paces a delta-sigma converter from the modulator clock. It merges two reset sources (a reset pin held low and a one-cycle reset-command strobe) and two start sources (a START pin level and a run flag set and cleared by start and stop command strobes). After any reset it holds a busy flag for a fixed initialisation window. It then times the first fully settled sample and every later sample from a rate code and a power-mode select. Its outputs are an active-low data-ready line, a one-cycle new-sample pulse and a flag that marks samples taken too soon after an input step.

The filter datapath, the register file and the serial command decoder sit outside the block; only their timing is modelled. A one-cycle configuration-write strobe stands for any write to the rate or respiration settings and restarts the settling window. The block is a five-state machine. INIT counts the initialisation window. IDLE waits for a run condition. SETTLE times the first sample. CONVERT times the repeating data period. HOLD parks after a single-shot result. The transitions are:
- INIT→SETTLE or INIT→IDLE when the window ends, depending on the run condition.
- IDLE→SETTLE when the run condition is present.
- SETTLE→CONVERT, SETTLE→HOLD or SETTLE→IDLE at a sample boundary, and CONVERT→CONVERT, CONVERT→HOLD or CONVERT→IDLE at a sample boundary.
- SETTLE→SETTLE and CONVERT→SETTLE on a restart.
- HOLD→SETTLE on a new start event, and HOLD→IDLE when the run condition drops.
- Any state→INIT on the reset strobe.

Top module: `conv_settle_seq`

## Requirements
- R1: While `rst_pin_n` is low, and in the cycle after a `cmd_reset` strobe, `init_busy` is 1, `drdy_n` is 1 and `sample_pulse` is 0. The reset strobe also clears the command run flag.
- R2: `init_busy` stays high for exactly 18 clock cycles after the pin is released or after the reset strobe's edge, then falls. If the run condition is present at that point, settling starts at once.
- R3: The run condition is `start_pin` OR the command run flag. `cmd_start` sets the flag and `cmd_stop` clears it, with stop winning if both strobes arrive together. When neither source is active, no sample is ever produced.
- R4: The first sample comes L cycles after the clock edge that accepts the start, with L = (288 << e) + 8 and e = rate code + `low_power`. In high-resolution mode this gives 296, 584, 1160, 2312, 4616, 9224 and 18440 for codes 0 to 6. In low-power mode it gives 584 to 36872. `drdy_n` is 1 from the accepting edge until that sample.
- R5: Rate code 7 behaves exactly like rate code 6.
- R6: In continuous mode, later samples follow every P = 256 << e cycles.
- R7: `drdy_n` falls only together with `sample_pulse`. Without a readback it stays low for P-1 cycles and rises one cycle before the next sample. A `rdback_done` strobe raises it on the next edge unless a sample lands on that same edge.
- R8: A `cfg_write` strobe or a new start event (a start command or a rising `start_pin`) during SETTLE or CONVERT restarts the settling window. The next sample then comes L cycles after that edge.
- R9: With `single_shot` = 1, a start yields exactly one sample and then HOLD. Only a new start event produces another sample.
- R10: When the run condition drops during a conversion, that conversion completes and delivers its sample at the boundary. After that no further sample is produced.
- R11: After a `step_mark` strobe, the next three samples carry `unsettled` = 1 and the fourth carries 0. `unsettled` is only ever high together with `sample_pulse`.
- R12: `sample_pulse` lasts one cycle and never coincides with `init_busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst_pin_n | input | 1 | Reset pin, active low, asynchronous assert |
| cmd_reset | input | 1 | One-cycle decoded reset command |
| cmd_start | input | 1 | One-cycle decoded start command |
| cmd_stop | input | 1 | One-cycle decoded stop command |
| start_pin | input | 1 | START pin level |
| rate_code | input | 3 | Data-rate code, 7 treated as 6 |
| low_power | input | 1 | 1 = low-power mode (half rate) |
| single_shot | input | 1 | 1 = one result per start |
| cfg_write | input | 1 | One-cycle strobe: rate or respiration setting written |
| rdback_done | input | 1 | One-cycle strobe: sample has been read |
| step_mark | input | 1 | One-cycle strobe: an input step occurred |
| drdy_n | output | 1 | Data ready, active low |
| init_busy | output | 1 | High during initialisation |
| sample_pulse | output | 1 | One-cycle pulse per new sample |
| unsettled | output | 1 | With `sample_pulse`: sample is within three of a step |

## Verification
The bound checker watches several rules on every cycle. These are the length of the busy window, the quiet outputs while busy and after a reset strobe, the rule that data-ready falls only with a sample pulse and rises after a readback, the single-cycle width of the sample pulse, and the confinement of the unsettled flag to sample cycles. The exact settling and period lengths for each rate and power mode can only be shown by the bench's timed scenarios. So can the 7-to-6 code mapping, the restart on a configuration write, the single-shot hold, the drain after a stop, and the count of three flagged samples after a step.

// File: rtl/conv_settle_seq_pkg.sv
package conv_settle_seq_pkg;

    typedef enum logic [2:0] {
        ST_INIT,
        ST_IDLE,
        ST_SETTLE,
        ST_CONVERT,
        ST_HOLD
    } seq_state_t;

endpackage

// File: rtl/cs_rate_timing.sv
module cs_rate_timing #(
    parameter int BASE_LOG2  = 8,
    parameter int CODE_W     = 3,
    parameter int MAX_CODE   = 6,
    parameter int SETTLE_PAD = 8,
    parameter int CNT_W      = 17
) (
    input  logic [CODE_W-1:0] rate_code,
    input  logic              low_power,
    output logic [CNT_W-1:0]  settle_len,
    output logic [CNT_W-1:0]  period_len
);
    localparam int EXP_W       = $clog2(MAX_CODE + 2);
    localparam int PERIOD_BASE = 1 << BASE_LOG2;
    // settling unit is one period plus one eighth of a period
    localparam int SETTLE_UNIT = PERIOD_BASE + (PERIOD_BASE >> 3);

    logic [CODE_W-1:0] code_eff;
    logic [EXP_W-1:0]  rate_exp;

    always_comb begin
        // reserved codes above the slowest rate fold onto it (R5)
        if (rate_code > CODE_W'(MAX_CODE)) begin
            code_eff = CODE_W'(MAX_CODE);
        end else begin
            code_eff = rate_code;
        end
        rate_exp   = EXP_W'(code_eff) + EXP_W'(low_power);
        period_len = CNT_W'(PERIOD_BASE) << rate_exp;
        settle_len = (CNT_W'(SETTLE_UNIT) << rate_exp) + CNT_W'(SETTLE_PAD);
    end

endmodule

// File: rtl/cs_run_ctrl.sv
module cs_run_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic cmd_start,
    input  logic cmd_stop,
    input  logic start_pin,
    output logic run_eff,
    output logic start_evt
);
    logic run_flag;
    logic pin_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_flag <= 1'b0;
            pin_q    <= 1'b0;
        end else begin
            pin_q <= start_pin;
            if (soft_rst || cmd_stop) begin
                run_flag <= 1'b0;
            end else if (cmd_start) begin
                run_flag <= 1'b1;
            end
        end
    end

    always_comb begin
        run_eff   = start_pin | run_flag;
        start_evt = (cmd_start & ~cmd_stop) | (start_pin & ~pin_q);
    end

endmodule

// File: rtl/cs_step_track.sv
module cs_step_track #(
    parameter int STEP_SAMPLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step_mark,
    input  logic sample_evt,
    output logic unsettled
);
    localparam int LEFT_W = $clog2(STEP_SAMPLES + 1);

    logic [LEFT_W-1:0] left;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left      <= '0;
            unsettled <= 1'b0;
        end else begin
            unsettled <= sample_evt && (step_mark || (left != '0));
            if (clear) begin
                left <= '0;
            end else if (step_mark) begin
                // a sample on the marking edge is the first of the flagged ones
                left <= sample_evt ? LEFT_W'(STEP_SAMPLES - 1) : LEFT_W'(STEP_SAMPLES);
            end else if (sample_evt && (left != '0)) begin
                left <= left - 1'b1;
            end
        end
    end

endmodule

// File: rtl/conv_settle_seq.sv
module conv_settle_seq
    import conv_settle_seq_pkg::*;
#(
    parameter int INIT_CYCLES  = 18,
    parameter int BASE_LOG2    = 8,
    parameter int CODE_W       = 3,
    parameter int MAX_CODE     = 6,
    parameter int SETTLE_PAD   = 8,
    parameter int STEP_SAMPLES = 3
) (
    input  logic              clk,
    input  logic              rst_pin_n,
    input  logic              cmd_reset,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic              start_pin,
    input  logic [CODE_W-1:0] rate_code,
    input  logic              low_power,
    input  logic              single_shot,
    input  logic              cfg_write,
    input  logic              rdback_done,
    input  logic              step_mark,
    output logic              drdy_n,
    output logic              init_busy,
    output logic              sample_pulse,
    output logic              unsettled
);
    localparam int CNT_W = BASE_LOG2 + MAX_CODE + 3;

    seq_state_t       state, state_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic [CNT_W-1:0] settle_len, period_len;
    logic             run_eff, start_evt;
    logic             sample_evt, enter_settle;

    cs_rate_timing #(
        .BASE_LOG2 (BASE_LOG2),
        .CODE_W    (CODE_W),
        .MAX_CODE  (MAX_CODE),
        .SETTLE_PAD(SETTLE_PAD),
        .CNT_W     (CNT_W)
    ) u_rate (
        .rate_code (rate_code),
        .low_power (low_power),
        .settle_len(settle_len),
        .period_len(period_len)
    );

    cs_run_ctrl u_run (
        .clk      (clk),
        .rst_n    (rst_pin_n),
        .soft_rst (cmd_reset),
        .cmd_start(cmd_start),
        .cmd_stop (cmd_stop),
        .start_pin(start_pin),
        .run_eff  (run_eff),
        .start_evt(start_evt)
    );

    cs_step_track #(
        .STEP_SAMPLES(STEP_SAMPLES)
    ) u_step (
        .clk       (clk),
        .rst_n     (rst_pin_n),
        .clear     (enter_settle | cmd_reset),
        .step_mark (step_mark),
        .sample_evt(sample_evt),
        .unsettled (unsettled)
    );

    // next-state and counter logic
    always_comb begin
        state_nxt    = state;
        cnt_nxt      = cnt + 1'b1;
        sample_evt   = 1'b0;
        enter_settle = 1'b0;
        if (cmd_reset) begin
            state_nxt = ST_INIT;
            cnt_nxt   = '0;
        end else begin
            unique case (state)
                ST_INIT: begin
                    if (cnt == CNT_W'(INIT_CYCLES - 1)) begin
                        cnt_nxt = '0;
                        if (run_eff) begin
                            state_nxt    = ST_SETTLE;
                            enter_settle = 1'b1;
                        end else begin
                            state_nxt = ST_IDLE;
                        end
                    end
                end
                ST_IDLE: begin
                    cnt_nxt = '0;
                    if (run_eff || start_evt) begin
                        state_nxt    = ST_SETTLE;
                        enter_settle = 1'b1;
                    end
                end
                ST_SETTLE, ST_CONVERT: begin
                    if (start_evt || cfg_write) begin
                        state_nxt    = ST_SETTLE;
                        cnt_nxt      = '0;
                        enter_settle = 1'b1;
                    end else if (cnt == ((state == ST_SETTLE) ? settle_len : period_len) - 1'b1) begin
                        sample_evt = 1'b1;
                        cnt_nxt    = '0;
                        if (!run_eff) begin
                            state_nxt = ST_IDLE;
                        end else if (single_shot) begin
                            state_nxt = ST_HOLD;
                        end else begin
                            state_nxt = ST_CONVERT;
                        end
                    end
                end
                ST_HOLD: begin
                    cnt_nxt = '0;
                    if (start_evt) begin
                        state_nxt    = ST_SETTLE;
                        enter_settle = 1'b1;
                    end else if (!run_eff) begin
                        state_nxt = ST_IDLE;
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_pin_n) begin
        if (!rst_pin_n) begin
            state <= ST_INIT;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_pin_n) begin
        if (!rst_pin_n) begin
            drdy_n       <= 1'b1;
            init_busy    <= 1'b1;
            sample_pulse <= 1'b0;
        end else begin
            init_busy    <= (state_nxt == ST_INIT);
            sample_pulse <= sample_evt;
            if (sample_evt) begin
                drdy_n <= 1'b0;
            end else if (cmd_reset || enter_settle || rdback_done) begin
                drdy_n <= 1'b1;
            end else if ((state == ST_CONVERT) && (cnt == period_len - 2'd2)) begin
                drdy_n <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/conv_settle_seq_chk.sv
module conv_settle_seq_chk #(
    parameter int INIT_CYCLES = 18
) (
    input logic clk,
    input logic rst_pin_n,
    input logic cmd_reset,
    input logic rdback_done,
    input logic init_busy,
    input logic drdy_n,
    input logic sample_pulse,
    input logic unsettled
);
    localparam int RUN_W = $clog2(INIT_CYCLES + 2) + 1;

    logic [RUN_W-1:0] busy_run;

    always_ff @(posedge clk or negedge rst_pin_n) begin
        if (!rst_pin_n) begin
            busy_run <= '0;
        end else if (cmd_reset || !init_busy) begin
            busy_run <= '0;
        end else begin
            busy_run <= busy_run + 1'b1;
        end
    end

    p_busy_bound_r2: assert property (@(posedge clk) disable iff (!rst_pin_n)
        init_busy |-> (busy_run < RUN_W'(INIT_CYCLES)));

    p_busy_ends_r2: assert property (@(posedge clk) disable iff (!rst_pin_n)
        (init_busy && !cmd_reset && (busy_run == RUN_W'(INIT_CYCLES - 1))) |=> !init_busy);

    p_reset_busy_r1: assert property (@(posedge clk) disable iff (!rst_pin_n)
        $past(cmd_reset) |-> (init_busy && drdy_n && !sample_pulse));

    p_busy_quiet_r12: assert property (@(posedge clk) disable iff (!rst_pin_n)
        init_busy |-> (drdy_n && !sample_pulse));

    p_pulse_once_r12: assert property (@(posedge clk) disable iff (!rst_pin_n)
        sample_pulse |=> !sample_pulse);

    p_drdy_fall_r7: assert property (@(posedge clk) disable iff (!rst_pin_n)
        $fell(drdy_n) |-> sample_pulse);

    p_rdback_release_r7: assert property (@(posedge clk) disable iff (!rst_pin_n)
        ($past(rdback_done) && !sample_pulse) |-> drdy_n);

    p_flag_with_sample_r11: assert property (@(posedge clk) disable iff (!rst_pin_n)
        unsettled |-> sample_pulse);

endmodule

bind conv_settle_seq conv_settle_seq_chk #(
    .INIT_CYCLES(INIT_CYCLES)
) u_chk (
    .clk         (clk),
    .rst_pin_n   (rst_pin_n),
    .cmd_reset   (cmd_reset),
    .rdback_done (rdback_done),
    .init_busy   (init_busy),
    .drdy_n      (drdy_n),
    .sample_pulse(sample_pulse),
    .unsettled   (unsettled)
);

// File: tb/conv_settle_seq_test.sv
module conv_settle_seq_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    localparam int S_RESET = 0;
    localparam int S_START = 1;
    localparam int S_STOP  = 2;
    localparam int S_CFG   = 3;
    localparam int S_RDBK  = 4;
    localparam int S_STEP  = 5;

    typedef struct packed {
        logic [2:0] code;
        logic       lp;
        int         settle;
        int         period;
    } row_t;

    localparam int NROWS = 11;
    localparam row_t ROWS [NROWS] = '{
        '{3'd0, 1'b0,   296,   256},
        '{3'd1, 1'b0,   584,   512},
        '{3'd2, 1'b0,  1160,  1024},
        '{3'd3, 1'b0,  2312,  2048},
        '{3'd4, 1'b0,  4616,  4096},
        '{3'd5, 1'b0,  9224,  8192},
        '{3'd6, 1'b0, 18440, 16384},
        '{3'd7, 1'b0, 18440, 16384},
        '{3'd0, 1'b1,   584,   512},
        '{3'd1, 1'b1,  1160,  1024},
        '{3'd3, 1'b1,  4616,  4096}
    };

    logic       clk = 1'b0;
    logic       rst_pin_n = 1'b0;
    logic       cmd_reset = 1'b0;
    logic       cmd_start = 1'b0;
    logic       cmd_stop = 1'b0;
    logic       start_pin = 1'b0;
    logic [2:0] rate_code = 3'd0;
    logic       low_power = 1'b0;
    logic       single_shot = 1'b0;
    logic       cfg_write = 1'b0;
    logic       rdback_done = 1'b0;
    logic       step_mark = 1'b0;
    logic       drdy_n;
    logic       init_busy;
    logic       sample_pulse;
    logic       unsettled;

    int  checks = 0;
    int  fails = 0;
    bit  finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    conv_settle_seq uut (
        .clk         (clk),
        .rst_pin_n   (rst_pin_n),
        .cmd_reset   (cmd_reset),
        .cmd_start   (cmd_start),
        .cmd_stop    (cmd_stop),
        .start_pin   (start_pin),
        .rate_code   (rate_code),
        .low_power   (low_power),
        .single_shot (single_shot),
        .cfg_write   (cfg_write),
        .rdback_done (rdback_done),
        .step_mark   (step_mark),
        .drdy_n      (drdy_n),
        .init_busy   (init_busy),
        .sample_pulse(sample_pulse),
        .unsettled   (unsettled)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic strobe(input int which);
        @(negedge clk);
        case (which)
            S_RESET: cmd_reset   = 1'b1;
            S_START: cmd_start   = 1'b1;
            S_STOP:  cmd_stop    = 1'b1;
            S_CFG:   cfg_write   = 1'b1;
            S_RDBK:  rdback_done = 1'b1;
            default: step_mark   = 1'b1;
        endcase
        tick();
        cmd_reset   = 1'b0;
        cmd_start   = 1'b0;
        cmd_stop    = 1'b0;
        cfg_write   = 1'b0;
        rdback_done = 1'b0;
        step_mark   = 1'b0;
    endtask

    task automatic count_until_sample(output int n, input int limit);
        n = 0;
        do begin
            tick();
            n++;
        end while (!sample_pulse && n < limit);
    endtask

    task automatic count_samples(output int n, input int span);
        n = 0;
        for (int i = 0; i < span; i++) begin
            tick();
            if (sample_pulse) n++;
        end
    endtask

    task automatic soft_restart();
        int n;
        strobe(S_RESET);
        n = 0;
        while (init_busy && n < 40) begin
            tick();
            n++;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int n;
        int m;

        // reset state through the pin (R1)
        repeat (3) @(negedge clk);
        check(init_busy == 1'b1 && drdy_n == 1'b1 && sample_pulse == 1'b0,
              "R1 pin reset outputs", {init_busy, drdy_n, sample_pulse}, 3'b110);
        @(negedge clk) rst_pin_n = 1'b1;
        n = 0;
        do begin
            tick();
            n++;
        end while (init_busy && n < 40);
        check(n == 18, "R2 busy after pin release", n, 18);

        // halted: no run source (R3)
        count_samples(n, 500);
        check(n == 0 && drdy_n == 1'b1, "R3 no sample while halted", n, 0);

        // rate and power mode table (R4, R5, R6)
        for (int r = 0; r < NROWS; r++) begin
            soft_restart();
            rate_code = ROWS[r].code;
            low_power = ROWS[r].lp;
            strobe(S_START);
            count_until_sample(n, ROWS[r].settle + 20);
            if (ROWS[r].code == 3'd7)
                check(n == ROWS[r].settle, "R5 reserved code settle", n, ROWS[r].settle);
            else
                check(n == ROWS[r].settle, "R4 first-sample delay", n, ROWS[r].settle);
            count_until_sample(n, ROWS[r].period + 20);
            check(n == ROWS[r].period, "R6 data period", n, ROWS[r].period);
        end
        rate_code = 3'd0;
        low_power = 1'b0;

        // pin start, data-ready shape and readback (R3, R7)
        soft_restart();
        @(negedge clk) start_pin = 1'b1;
        tick();
        count_until_sample(n, 400);
        check(n == 296, "R3 pin start settle", n, 296);
        check(drdy_n == 1'b0, "R7 drdy low with sample", drdy_n, 0);
        n = 0;
        do begin
            tick();
            n++;
        end while (drdy_n == 1'b0 && n < 400);
        check(n == 255, "R7 drdy low length", n, 255);
        tick();
        check(sample_pulse == 1'b1 && drdy_n == 1'b0, "R7 drdy falls at boundary",
              {sample_pulse, drdy_n}, 2'b10);
        tick();
        strobe(S_RDBK);
        check(drdy_n == 1'b1, "R7 readback releases drdy", drdy_n, 1);
        @(negedge clk) start_pin = 1'b0;
        count_until_sample(n, 400);
        count_samples(m, 600);
        check(m == 0, "R10 halt after pin drop", m, 0);

        // stop command drains current conversion (R10)
        soft_restart();
        strobe(S_START);
        count_until_sample(n, 400);
        repeat (100) tick();
        strobe(S_STOP);
        count_until_sample(n, 400);
        check(n == 155, "R10 final sample at boundary", n, 155);
        count_samples(m, 600);
        check(m == 0, "R10 no sample after stop", m, 0);

        // configuration write restarts settling (R8)
        soft_restart();
        strobe(S_START);
        repeat (100) tick();
        strobe(S_CFG);
        count_until_sample(n, 400);
        check(n == 296, "R8 cfg write in settle", n, 296);
        repeat (50) tick();
        strobe(S_CFG);
        count_until_sample(n, 400);
        check(n == 296, "R8 cfg write in convert", n, 296);

        // single shot (R9)
        soft_restart();
        single_shot = 1'b1;
        strobe(S_START);
        count_until_sample(n, 400);
        check(n == 296, "R9 single-shot first sample", n, 296);
        count_samples(m, 1000);
        check(m == 0, "R9 only one sample per start", m, 0);
        strobe(S_START);
        count_until_sample(n, 400);
        check(n == 296, "R9 second start", n, 296);
        single_shot = 1'b0;

        // step marking (R11)
        soft_restart();
        strobe(S_START);
        count_until_sample(n, 400);
        check(unsettled == 1'b0, "R11 clean first sample", unsettled, 0);
        repeat (10) tick();
        strobe(S_STEP);
        for (int k = 1; k <= 4; k++) begin
            count_until_sample(n, 400);
            check(unsettled == (k <= 3), "R11 step flag", unsettled, (k <= 3));
        end

        // reset command during conversion (R1, R2)
        strobe(S_RESET);
        check(init_busy == 1'b1 && drdy_n == 1'b1 && sample_pulse == 1'b0,
              "R1 reset command outputs", {init_busy, drdy_n, sample_pulse}, 3'b110);
        n = 0;
        do begin
            tick();
            n++;
        end while (init_busy && n < 40);
        check(n == 18, "R2 busy after reset command", n, 18);
        count_samples(m, 600);
        check(m == 0, "R1 run flag cleared by reset", m, 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule